// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold Detect

This block is the digital controller around a successive-approximation analog-to-digital converter. Software writes a 7-bit command word holding a channel number, a start source, one of four modes and an interrupt enable. A conversion starts either at once on the command write or on a later trigger pulse from an event timer. The block then counts a sample phase and a conversion phase in clock cycles. It steers an external channel multiplexer and walks a trial code past an external comparator one bit per cycle. When the conversion phase ends it stores the result and raises a pending flag.

The two threshold modes do not store a result. Before the start, a compare byte is written into the result high byte. The 8-bit code is compared against that byte. The pending flag is raised only when the code is above the byte (detect-high) or below it (detect-low). The phase lengths come from two configuration inputs. A value outside the legal window for the current mode is pulled to the nearest limit.

Top module: `adc_seq`

## Requirements
- R1: A command write with the start-source bit (bit 3) at 0, while not busy, starts sampling. `busy` is high in the cycle after the write.
- R2: A command write with bit 3 at 1 only arms the block, and `busy` stays low. A `trig` pulse while armed starts sampling in the next cycle. A `trig` pulse while idle and not armed has no effect.
- R3: `mux_sel` shows the channel field, command bits 2:0, of the last accepted command. There are eight channels by default, and the field is cut to log2 of the `NCH` parameter.
- R4: In mode 1 (bits 5:4 = 01, 10-bit), `result` receives the 10-bit code in bits 15:6, and bits 5:0 are zero.
- R5: In mode 0 (bits 5:4 = 00, 8-bit), `result` receives the upper eight code bits in bits 15:8, and bits 7:0 are zero.
- R6: `busy` stays high for exactly S + C cycles. S is `samp_cycles` limited to the range 10 to 58, and C is the conversion length from R7.
- R7: C is `conv_cycles` limited to 63..643 in 10-bit mode. In all other modes it is limited to 51..515.
- R8: `thr_wr` loads `result` with {`thr_data`, 8'h00}. In mode 2 (bits 5:4 = 10, detect-high), completion leaves `result` unchanged. It sets `pend` only when the 8-bit code is greater than result[15:8].
- R9: In mode 3 (bits 5:4 = 11, detect-low), completion leaves `result` unchanged. It sets `pend` only when the 8-bit code is less than result[15:8].
- R10: Every completion in modes 0 and 1 sets `pend`. `irq` equals `pend` AND the interrupt-enable bit, which is command bit 6.
- R11: A command write or a `trig` pulse while `busy` is high is ignored. The channel, the mode and the busy length do not change.
- R12: A `pend_clr` pulse clears `pend`. When a completion falls in the same cycle as a clear, `pend` is set.
- R13: After synchronous reset, `busy`, `pend` and `irq` are low, and `result` and `mux_sel` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 7 | Command word: ie[6], mode[5:4], src[3], channel[2:0] |
| trig | input | 1 | External event trigger pulse |
| samp_cycles | input | 6 | Requested sample phase length in clocks |
| conv_cycles | input | 10 | Requested conversion phase length in clocks |
| thr_wr | input | 1 | Threshold byte write strobe |
| thr_data | input | 8 | Threshold byte |
| pend_clr | input | 1 | Write-one clear of the pending flag |
| cmp_hi | input | 1 | Comparator: analog input is at or above the trial code |
| busy | output | 1 | Sampling or converting |
| pend | output | 1 | Completion pending flag |
| irq | output | 1 | Completion interrupt |
| result | output | 16 | Result register |
| mux_sel | output | 3 | Analog channel multiplexer select |
| sar_trial | output | 10 | Trial code for the comparator |

## Verification
A table of vectors runs every mode with analog levels at zero, at full scale and at alternating-bit codes. Bit-order or truncation faults in the approximation loop therefore show up in `result`. Sample and conversion requests below, inside and above their windows are measured by the busy length. This separates the 8-bit and 10-bit conversion limits. Threshold vectors put the code one step above, equal to and one step below the compare byte. This separates strict from non-strict comparison and high from low detection. Directed cases cover the armed start and a stray trigger, writes during a conversion, and a clear that lands on the completion cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAR_W   = 10;
    localparam int BYTE_W  = 8;
    localparam int RES_W   = 16;

    localparam logic [15:0] SAMP_MIN = 16'd10;
    localparam logic [15:0] SAMP_MAX = 16'd58;
    localparam logic [15:0] C8_MIN   = 16'd51;
    localparam logic [15:0] C8_MAX   = 16'd515;
    localparam logic [15:0] C10_MIN  = 16'd63;
    localparam logic [15:0] C10_MAX  = 16'd643;

    typedef enum logic [1:0] {
        MD_B8  = 2'd0,
        MD_B10 = 2'd1,
        MD_THI = 2'd2,
        MD_TLO = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_SAMP,
        ST_CONV
    } state_e;

    typedef struct packed {
        logic       ie;
        mode_e      mode;
        logic       src;
        logic [2:0] ch;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [6:0] w);
        cmd_t c;
        c.ie   = w[6];
        c.mode = mode_e'(w[5:4]);
        c.src  = w[3];
        c.ch   = w[2:0];
        return c;
    endfunction

    function automatic logic [15:0] clampv(input logic [15:0] v,
                                           input logic [15:0] lo,
                                           input logic [15:0] hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [15:0] conv_len(input logic [15:0] v, input mode_e m);
        if (m == MD_B10) return clampv(v, C10_MIN, C10_MAX);
        return clampv(v, C8_MIN, C8_MAX);
    endfunction

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int CNT_W   = 10,
    parameter int CNT_MAX = 643
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val - 1'b1;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

    // R7: a loaded phase never exceeds the longest legal window
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CNT_MAX - 1));

    // R6: the count only moves down while running, or on a load
    assert_cnt_monotonic_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(load) && !$past(rst) |-> cnt <= $past(cnt));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int W     = 10,
    parameter int SHORT = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         step_req,
    input  logic         short_mode,
    input  logic         cmp_hi,
    output logic [W-1:0] trial,
    output logic [W-1:0] code
);
    localparam int STOP_BIT = W - 1 - SHORT;

    logic [W-1:0] acc;
    logic [W-1:0] mask;
    logic         active;

    assign active = (mask != '0) && !(short_mode && (|mask[STOP_BIT:0]));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            mask <= '0;
        end else if (init) begin
            acc  <= '0;
            mask <= {1'b1, {(W-1){1'b0}}};
        end else if (step_req && active) begin
            if (cmp_hi)
                acc <= acc | mask;
            mask <= mask >> 1;
        end
    end

    assign trial = acc | mask;
    assign code  = acc;

    // R4: exactly one trial bit, or none, is under test at a time
    assert_mask_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask));

    // R5: a short (8-bit) walk never resolves the two lowest code bits
    assert_short_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
        short_mode && !$past(init) && $past(short_mode) && $past(acc[1:0]) == 2'b00
        |-> acc[1:0] == 2'b00);

endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SAMP_W = 6,
    parameter int CONV_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_wr,
    input  logic [6:0]              cmd_data,
    input  logic                    trig,
    input  logic [SAMP_W-1:0]       samp_cycles,
    input  logic [CONV_W-1:0]       conv_cycles,
    input  logic                    thr_wr,
    input  logic [7:0]              thr_data,
    input  logic                    pend_clr,
    input  logic                    cmp_hi,
    output logic                    busy,
    output logic                    pend,
    output logic                    irq,
    output logic [15:0]             result,
    output logic [$clog2(NCH)-1:0]  mux_sel,
    output logic [SAR_W-1:0]        sar_trial
);
    localparam int CH_W = $clog2(NCH);

    state_e            st;
    cmd_t              cmd_q;
    cmd_t              cmd_new;
    logic              accept;
    logic              go;
    logic              samp_end;
    logic              conv_end;
    logic              tmr_last;
    logic              tmr_load;
    logic [CONV_W-1:0] tmr_val;
    logic [SAR_W-1:0]  code;
    logic [BYTE_W-1:0] code8;
    logic              hit;

    assign cmd_new  = decode_cmd(cmd_data);
    assign busy     = (st == ST_SAMP) || (st == ST_CONV);
    assign accept   = cmd_wr && !busy;
    assign go       = (accept && !cmd_new.src) || (st == ST_ARM && trig && !cmd_wr);
    assign samp_end = (st == ST_SAMP) && tmr_last;
    assign conv_end = (st == ST_CONV) && tmr_last;
    assign tmr_load = go || samp_end;
    assign tmr_val  = go ? CONV_W'(clampv(16'(samp_cycles), SAMP_MIN, SAMP_MAX))
                         : CONV_W'(conv_len(16'(conv_cycles), cmd_q.mode));

    adc_phase_timer #(.CNT_W(CONV_W), .CNT_MAX(int'(C10_MAX))) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (busy),
        .last     (tmr_last)
    );

    adc_sar_core #(.W(SAR_W), .SHORT(BYTE_W)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .init       (samp_end),
        .step_req   (st == ST_CONV),
        .short_mode (cmd_q.mode != MD_B10),
        .cmp_hi     (cmp_hi),
        .trial      (sar_trial),
        .code       (code)
    );

    assign code8 = code[SAR_W-1 -: BYTE_W];

    always_comb begin
        case (cmd_q.mode)
            MD_THI:  hit = code8 > result[RES_W-1 -: BYTE_W];
            MD_TLO:  hit = code8 < result[RES_W-1 -: BYTE_W];
            default: hit = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            if (accept)
                cmd_q <= cmd_new;
            case (st)
                ST_IDLE, ST_ARM: begin
                    if (go)
                        st <= ST_SAMP;
                    else if (accept)
                        st <= ST_ARM;
                end
                ST_SAMP: if (tmr_last) st <= ST_CONV;
                ST_CONV: if (tmr_last) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (conv_end && cmd_q.mode == MD_B10)
            result <= {code, {(RES_W-SAR_W){1'b0}}};
        else if (conv_end && cmd_q.mode == MD_B8)
            result <= {code8, {(RES_W-BYTE_W){1'b0}}};
        else if (thr_wr)
            result <= {thr_data, {(RES_W-BYTE_W){1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (conv_end && hit)
            pend <= 1'b1;
        else if (pend_clr)
            pend <= 1'b0;
    end

    assign irq     = pend && cmd_q.ie;
    assign mux_sel = cmd_q.ch[CH_W-1:0];

    assert_cmd_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_wr |=> $stable(mux_sel));

    assert_irq_needs_pend_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> pend);

    assert_pend_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> $past(pend_clr));

    assert_result_source_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> $past(thr_wr) || $fell(busy));

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_wr) || $past(trig));

endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;

    typedef struct packed {
        logic [6:0] cmd;
        logic [5:0] samp;
        logic [9:0] conv;
        logic [9:0] ana;
        logic [7:0] thr;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{7'h51, 6'd20, 10'd100,  10'h2A5, 8'h00},
        '{7'h02, 6'd5,  10'd40,   10'h3FF, 8'h00},
        '{7'h13, 6'd63, 10'd1000, 10'h000, 8'h00},
        '{7'h14, 6'd10, 10'd50,   10'h155, 8'h00},
        '{7'h05, 6'd58, 10'd600,  10'h0C7, 8'h00},
        '{7'h66, 6'd12, 10'd60,   10'h200, 8'h7F},
        '{7'h27, 6'd12, 10'd60,   10'h200, 8'h80},
        '{7'h70, 6'd12, 10'd60,   10'h1FC, 8'h80},
        '{7'h31, 6'd12, 10'd60,   10'h300, 8'h80}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [6:0]  cmd_data = '0;
    logic        trig = 1'b0;
    logic [5:0]  samp_cycles = 6'd10;
    logic [9:0]  conv_cycles = 10'd51;
    logic        thr_wr = 1'b0;
    logic [7:0]  thr_data = '0;
    logic        pend_clr = 1'b0;
    logic        cmp_hi;
    logic        busy, pend, irq;
    logic [15:0] result;
    logic [2:0]  mux_sel;
    logic [9:0]  sar_trial;
    logic [9:0]  ana [8];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign cmp_hi = (ana[mux_sel] >= sar_trial);

    adc_seq u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .trig(trig),
        .samp_cycles(samp_cycles), .conv_cycles(conv_cycles), .thr_wr(thr_wr),
        .thr_data(thr_data), .pend_clr(pend_clr), .cmp_hi(cmp_hi), .busy(busy),
        .pend(pend), .irq(irq), .result(result), .mux_sel(mux_sel), .sar_trial(sar_trial)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int clip(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic wr_cmd(input logic [6:0] c);
        cmd_wr = 1'b1;
        cmd_data = c;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic clear_pend();
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] c8;
        logic [15:0] er;
        logic ep;
        for (int i = 0; i < 8; i++) ana[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13: reset state
        chk("R13 busy", busy, 0);
        chk("R13 pend", pend, 0);
        chk("R13 irq", irq, 0);
        chk("R13 result", result, 0);
        chk("R13 mux_sel", mux_sel, 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0] md;
            int nexp;
            md = VECS[v].cmd[5:4];
            if (md[1]) begin
                thr_data = VECS[v].thr;
                thr_wr = 1'b1;
                @(negedge clk);
                thr_wr = 1'b0;
                chk("R8 thr load", result, {VECS[v].thr, 8'h00});
            end
            ana[VECS[v].cmd[2:0]] = VECS[v].ana;
            samp_cycles = VECS[v].samp;
            conv_cycles = VECS[v].conv;
            wr_cmd(VECS[v].cmd);
            chk("R1 start", busy, 1);
            chk("R3 mux_sel", mux_sel, VECS[v].cmd[2:0]);
            count_busy(n);
            nexp = clip(int'(VECS[v].samp), 10, 58) +
                   ((md == 2'b01) ? clip(int'(VECS[v].conv), 63, 643)
                                  : clip(int'(VECS[v].conv), 51, 515));
            chk("R6 R7 busy length", n, nexp);
            c8 = VECS[v].ana[9:2];
            case (md)
                2'b00: begin er = {c8, 8'h00}; ep = 1'b1; chk("R5 result", result, er); end
                2'b01: begin er = {VECS[v].ana, 6'b0}; ep = 1'b1; chk("R4 result", result, er); end
                2'b10: begin er = {VECS[v].thr, 8'h00}; ep = c8 > VECS[v].thr; chk("R8 result kept", result, er); end
                default: begin er = {VECS[v].thr, 8'h00}; ep = c8 < VECS[v].thr; chk("R9 result kept", result, er); end
            endcase
            chk(md[1] ? (md[0] ? "R9 pend" : "R8 pend") : "R10 pend", pend, ep);
            chk("R10 irq", irq, ep & VECS[v].cmd[6]);
            clear_pend();
            chk("R12 clear", pend, 0);
        end

        // R2: armed start, R11: writes and triggers during busy ignored
        ana[2] = 10'h2C4;
        samp_cycles = 6'd10;
        conv_cycles = 10'd51;
        wr_cmd(7'h0A);
        repeat (5) @(negedge clk);
        chk("R2 armed idle", busy, 0);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk("R2 trig start", busy, 1);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            if (n == 5) begin cmd_wr = 1'b1; cmd_data = 7'h15; trig = 1'b1; end
            else begin cmd_wr = 1'b0; trig = 1'b0; end
            @(negedge clk);
        end
        cmd_wr = 1'b0;
        trig = 1'b0;
        chk("R11 busy length", n, 61);
        chk("R11 mux_sel", mux_sel, 2);
        chk("R11 mode kept", result, {8'hB1, 8'h00});
        clear_pend();

        // R2: stray trigger while idle and not armed
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        @(negedge clk);
        chk("R2 stray trig", busy, 0);

        // R12: clear in the completion cycle loses to the new completion
        wr_cmd(7'h01);
        repeat (60) @(negedge clk);
        chk("R12 still busy", busy, 1);
        pend_clr = 1'b1;
        @(negedge clk);
        pend_clr = 1'b0;
        chk("R12 done", busy, 0);
        chk("R12 set wins", pend, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule